// File: doc/BRIEF.md
# Runtime-Configurable Decimating FIR with Output Gain

This block is a programmable FIR filter placed after a chain of fixed decimators. Software picks, at run time, whether the filter is bypassed or decimates by 1, 2 or 4. It also picks a length of 24, 48 or 72 taps and one of four output gains. The coefficients sit in a writable store, so the response can be shaped to flatten the droop of an earlier analog low-pass stage.

A bank of `LANES` multipliers is shared in time. It runs on a processing clock that is faster than the sample rate. Each pass of the bank covers `LANES` taps, so a longer filter takes more passes per output.

The host states how many processing clocks separate two input samples (`cfg_ratio`). The block rejects any setting whose pass count exceeds the clocks available per output sample. In effect, the longest legal filter is 24 taps times the ratio of processing clock to output rate.

Top module: `fir_decim_prog`

## Requirements
- R1: While `cfg_en` is 0, or `cfg_mode` is 0 (bypass), each sample is copied unchanged to the output. `out_valid`/`out_data` equal `in_valid`/`in_data` of the previous clock. After reset, `out_valid` and `cfg_err` are 0.
- R2: In filter mode each output equals sat(floor(S·2^g / 2^(CW-1))). Here S = Σ c[k]·x[n-k] over the first N taps, c[0] applies to the newest accepted sample, and coefficients are signed with CW-1 fraction bits.
- R3: `cfg_mode` 1, 2 and 3 select decimation by 1, 2 and 4. After a clear, every D-th accepted sample starts exactly one output, computed with that sample as the newest.
- R4: `cfg_taps` 0, 1 and 2 select N = 24, 48 and 72 taps, taking 1, 2 and 3 passes. Coefficients at index N or above have no effect on the output.
- R5: `cfg_gain` 0, 1, 2 and 3 select g = +1, 0, -1 and -2 (+6, 0, -6 and -12 dB). The gain is applied as an arithmetic shift of the full-precision sum.
- R6: A scaled result above 2^(DW-1)-1 or below -2^(DW-1) is clamped to that limit.
- R7: With `cfg_en`=1 and a non-zero mode, `cfg_err` is 1 when `cfg_taps`=3, or when the pass count exceeds `cfg_ratio`·D. While `cfg_err` is 1, the block behaves as in bypass.
- R8: A write on `coef_we` stores `coef_data` at tap index `coef_addr`, but only while the registered enable is 0. Writes made while enabled leave the coefficients unchanged.
- R9: A change to any configuration input clears the delay line, the decimation phase and any output in progress. The sample offered in the clock of the change is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | processing clock |
| rst | input | 1 | synchronous active-high reset |
| cfg_en | input | 1 | filter enable; 0 locks out nothing and allows coefficient writes |
| cfg_mode | input | 2 | 0 bypass, 1/2/3 decimate by 1/2/4 |
| cfg_taps | input | 2 | 0/1/2 for 24/48/72 taps, 3 reserved |
| cfg_gain | input | 2 | 0 +6 dB, 1 0 dB, 2 -6 dB, 3 -12 dB |
| cfg_ratio | input | RW | processing clocks between input samples |
| coef_we | input | 1 | coefficient write strobe |
| coef_addr | input | AW | tap index to write |
| coef_data | input | CW | signed coefficient value |
| in_valid | input | 1 | input sample strobe |
| in_data | input | DW | signed input sample |
| out_valid | output | 1 | output sample strobe |
| out_data | output | DW | signed output sample |
| cfg_err | output | 1 | illegal configuration, block forced to bypass |

## Verification
Every legal combination of length, decimation and gain is tried with three patterns:
- A single impulse followed by zeros. This traces each coefficient to its output position, shows which taps a given length ignores, and shows which phase a decimation factor keeps.
- A positive constant and a negative constant. These exercise the whole sum together with the shift and rounding toward minus infinity, and show saturation at both rails.

Further runs cover the remaining rules:
- Short random-looking streams in bypass and disabled states.
- Settings that are just legal and just illegal, with back-to-back samples.
- A coefficient write attempted while enabled.
- A configuration change made with a half-filled decimation phase, where any left-over history would shift the impulse response.

// File: rtl/fir_pkg.sv
package fir_pkg;

  typedef enum logic [1:0] {
    MODE_PASS = 2'd0,
    MODE_D1   = 2'd1,
    MODE_D2   = 2'd2,
    MODE_D4   = 2'd3
  } mode_e;

  typedef enum logic [1:0] {
    GAIN_UP6  = 2'd0,
    GAIN_UNIT = 2'd1,
    GAIN_DN6  = 2'd2,
    GAIN_DN12 = 2'd3
  } gain_e;

  typedef struct packed {
    logic       en;
    logic [1:0] mode;
    logic [1:0] taps;
    logic [1:0] gain;
  } cfg_t;

  function automatic logic [2:0] dec_of(input logic [1:0] mode);
    case (mode_e'(mode))
      MODE_D2: return 3'd2;
      MODE_D4: return 3'd4;
      default: return 3'd1;
    endcase
  endfunction

endpackage

// File: rtl/fir_cfg_check.sv
module fir_cfg_check
  import fir_pkg::*;
#(
  parameter int RW      = 4,
  parameter int MAXPASS = 3,
  localparam int PW     = $clog2(MAXPASS + 1)
) (
  input  logic          en,
  input  logic [1:0]    mode,
  input  logic [1:0]    taps,
  input  logic [RW-1:0] ratio,
  output logic          active,
  output logic          err,
  output logic [PW-1:0] passes,
  output logic [2:0]    dec
);
  logic [2:0]    need;
  logic [RW+2:0] avail;
  logic          want;
  logic          bad;

  always_comb begin
    dec    = dec_of(mode);
    need   = {1'b0, taps} + 3'd1;
    avail  = (RW+3)'(ratio) * (RW+3)'(dec);
    bad    = (int'(need) > MAXPASS) || ((RW+3)'(need) > avail);
    want   = en && (mode_e'(mode) != MODE_PASS);
    err    = want && bad;
    active = want && !bad;
    passes = PW'(need);
  end
endmodule

// File: rtl/fir_coef_store.sv
module fir_coef_store #(
  parameter int CW = 16,
  parameter int NT = 72,
  localparam int AW = $clog2(NT)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    addr,
  input  logic [CW-1:0]    wdata,
  output logic [NT*CW-1:0] coef_flat
);
  logic [CW-1:0] mem [NT];

  always_ff @(posedge clk) begin
    if (we && (int'(addr) < NT)) mem[addr] <= wdata;
  end

  for (genvar i = 0; i < NT; i++) begin : g_out
    assign coef_flat[i*CW +: CW] = mem[i];
  end
endmodule

// File: rtl/fir_tap_line.sv
module fir_tap_line #(
  parameter int DW = 16,
  parameter int NT = 72
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             shift,
  input  logic             snap_en,
  input  logic [DW-1:0]    din,
  output logic [NT*DW-1:0] snap_flat
);
  logic [DW-1:0] dl [NT];
  logic [DW-1:0] sn [NT];

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      for (int i = 0; i < NT; i++) dl[i] <= '0;
    end else if (shift) begin
      dl[0] <= din;
      for (int i = 1; i < NT; i++) dl[i] <= dl[i-1];
    end
  end

  // snapshot holds the post-shift history for the whole multi-pass sum
  always_ff @(posedge clk) begin
    if (snap_en) begin
      sn[0] <= din;
      for (int i = 1; i < NT; i++) sn[i] <= dl[i-1];
    end
  end

  for (genvar i = 0; i < NT; i++) begin : g_out
    assign snap_flat[i*DW +: DW] = sn[i];
  end
endmodule

// File: rtl/fir_mac_bank.sv
module fir_mac_bank #(
  parameter int DW      = 16,
  parameter int CW      = 16,
  parameter int LANES   = 24,
  parameter int MAXPASS = 3,
  localparam int NT     = LANES * MAXPASS,
  localparam int PW     = $clog2(MAXPASS + 1),
  localparam int PRW    = DW + CW,
  localparam int SW     = PRW + $clog2(LANES) + 1
) (
  input  logic [NT*DW-1:0]     samp_flat,
  input  logic [NT*CW-1:0]     coef_flat,
  input  logic [PW-1:0]        pass,
  output logic signed [SW-1:0] partial
);
  logic signed [PRW-1:0] prod [LANES];

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic signed [CW-1:0] c_sel;
    logic signed [DW-1:0] s_sel;
    always_comb begin
      c_sel = '0;
      s_sel = '0;
      for (int p = 0; p < MAXPASS; p++) begin
        if (int'(pass) == p) begin
          c_sel = coef_flat[(p*LANES+k)*CW +: CW];
          s_sel = samp_flat[(p*LANES+k)*DW +: DW];
        end
      end
    end
    assign prod[k] = c_sel * s_sel;
  end

  always_comb begin
    partial = '0;
    for (int k = 0; k < LANES; k++) partial = partial + SW'(prod[k]);
  end
endmodule

// File: rtl/fir_decim_prog.sv
module fir_decim_prog
  import fir_pkg::*;
#(
  parameter int DW      = 16,
  parameter int CW      = 16,
  parameter int LANES   = 24,
  parameter int MAXPASS = 3,
  parameter int RW      = 4,
  localparam int NT     = LANES * MAXPASS,
  localparam int AW     = $clog2(NT)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_en,
  input  logic [1:0]    cfg_mode,
  input  logic [1:0]    cfg_taps,
  input  logic [1:0]    cfg_gain,
  input  logic [RW-1:0] cfg_ratio,
  input  logic          coef_we,
  input  logic [AW-1:0] coef_addr,
  input  logic [CW-1:0] coef_data,
  input  logic          in_valid,
  input  logic [DW-1:0] in_data,
  output logic          out_valid,
  output logic [DW-1:0] out_data,
  output logic          cfg_err
);
  localparam int PW   = $clog2(MAXPASS + 1);
  localparam int SW   = DW + CW + $clog2(LANES) + 1;
  localparam int ACCW = DW + CW + $clog2(NT) + 1;
  localparam int FRAC = CW - 1;
  localparam logic signed [ACCW-1:0] SMAX = ACCW'(2**(DW-1) - 1);
  localparam logic signed [ACCW-1:0] SMIN = -SMAX - 1;

  cfg_t                   cfg_in, cfg_q;
  logic [RW-1:0]          ratio_q;
  logic                   cfg_chg;
  logic                   active, err;
  logic [PW-1:0]          passes, pass;
  logic [2:0]             dec, phase;
  logic                   busy, last_ph, trig;
  logic [NT*CW-1:0]       coef_flat;
  logic [NT*DW-1:0]       snap_flat;
  logic signed [SW-1:0]   partial;
  logic signed [ACCW-1:0] acc, total, scaled;
  logic [DW-1:0]          y_sat;

  assign cfg_in  = '{en: cfg_en, mode: cfg_mode, taps: cfg_taps, gain: cfg_gain};
  assign cfg_chg = (cfg_in != cfg_q) || (cfg_ratio != ratio_q);
  assign last_ph = (phase == dec - 3'd1);
  assign trig    = active && !cfg_chg && in_valid && last_ph;
  assign cfg_err = err;

  fir_cfg_check #(.RW(RW), .MAXPASS(MAXPASS)) u_check (
    .en(cfg_q.en), .mode(cfg_q.mode), .taps(cfg_q.taps), .ratio(ratio_q),
    .active(active), .err(err), .passes(passes), .dec(dec)
  );

  fir_coef_store #(.CW(CW), .NT(NT)) u_coef (
    .clk(clk), .we(coef_we && !cfg_q.en), .addr(coef_addr), .wdata(coef_data),
    .coef_flat(coef_flat)
  );

  fir_tap_line #(.DW(DW), .NT(NT)) u_line (
    .clk(clk), .rst(rst), .clr(cfg_chg),
    .shift(active && in_valid && !cfg_chg), .snap_en(trig),
    .din(in_data), .snap_flat(snap_flat)
  );

  fir_mac_bank #(.DW(DW), .CW(CW), .LANES(LANES), .MAXPASS(MAXPASS)) u_mac (
    .samp_flat(snap_flat), .coef_flat(coef_flat), .pass(pass), .partial(partial)
  );

  always_comb begin
    total = acc + partial;
    case (gain_e'(cfg_q.gain))
      GAIN_UP6:  scaled = total >>> (FRAC - 1);
      GAIN_UNIT: scaled = total >>> FRAC;
      GAIN_DN6:  scaled = total >>> (FRAC + 1);
      default:   scaled = total >>> (FRAC + 2);
    endcase
    if (scaled > SMAX)      y_sat = SMAX[DW-1:0];
    else if (scaled < SMIN) y_sat = SMIN[DW-1:0];
    else                    y_sat = scaled[DW-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q     <= '0;
      ratio_q   <= '0;
      phase     <= '0;
      busy      <= 1'b0;
      pass      <= '0;
      acc       <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      cfg_q   <= cfg_in;
      ratio_q <= cfg_ratio;
      if (cfg_chg) begin
        phase     <= '0;
        busy      <= 1'b0;
        pass      <= '0;
        acc       <= '0;
        out_valid <= 1'b0;
      end else if (!active) begin
        out_valid <= in_valid;
        out_data  <= in_data;
        busy      <= 1'b0;
      end else begin
        out_valid <= 1'b0;
        if (in_valid) phase <= last_ph ? 3'd0 : phase + 3'd1;
        if (busy) begin
          if (pass == passes - 1'b1) begin
            out_valid <= 1'b1;
            out_data  <= y_sat;
            busy      <= 1'b0;
          end else begin
            pass <= pass + 1'b1;
            acc  <= total;
          end
        end
        if (trig) begin
          busy <= 1'b1;
          pass <= '0;
          acc  <= '0;
        end
      end
    end
  end
endmodule

// File: rtl/fir_decim_prog_chk.sv
module fir_decim_prog_chk #(
  parameter int DW = 16,
  parameter int CW = 16,
  parameter int NT = 72,
  parameter int PW = 2
) (
  input logic          clk,
  input logic          rst,
  input logic          cfg_chg,
  input logic          active,
  input logic          busy,
  input logic [PW-1:0] pass,
  input logic [PW-1:0] passes,
  input logic [2:0]    phase,
  input logic [2:0]    dec,
  input logic          in_valid,
  input logic [DW-1:0] in_data,
  input logic          out_valid,
  input logic [DW-1:0] out_data,
  input logic          coef_we,
  input logic          en_q,
  input logic [NT*CW-1:0] coef_flat,
  input logic          cfg_err
);
  assert_pass_through_R1: assert property (@(posedge clk) disable iff (rst)
    (!active && !cfg_chg && in_valid) |=> (out_valid && out_data == $past(in_data)));

  assert_phase_bound_R3: assert property (@(posedge clk) disable iff (rst)
    active |-> (phase < dec));

  assert_pass_bound_R4: assert property (@(posedge clk) disable iff (rst)
    busy |-> (pass < passes));

  assert_err_idle_R7: assert property (@(posedge clk) disable iff (rst)
    cfg_err |-> !busy);

  assert_coef_locked_R8: assert property (@(posedge clk) disable iff (rst)
    (coef_we && en_q) |=> $stable(coef_flat));

  assert_clear_on_change_R9: assert property (@(posedge clk) disable iff (rst)
    cfg_chg |=> (!busy && phase == 3'd0 && !out_valid));
endmodule

bind fir_decim_prog fir_decim_prog_chk #(.DW(DW), .CW(CW), .NT(NT), .PW($clog2(MAXPASS + 1))) u_chk (
  .clk(clk), .rst(rst), .cfg_chg(cfg_chg), .active(active), .busy(busy),
  .pass(pass), .passes(passes), .phase(phase), .dec(dec),
  .in_valid(in_valid), .in_data(in_data), .out_valid(out_valid), .out_data(out_data),
  .coef_we(coef_we), .en_q(cfg_q.en), .coef_flat(coef_flat), .cfg_err(cfg_err)
);

// File: tb/tb_fir_decim_prog.sv
module tb_fir_decim_prog;
  localparam int DW = 16, CW = 16, NT = 72, AW = 7, RW = 4;

  logic          clk = 0, rst = 1;
  logic          cfg_en = 0, coef_we = 0, in_valid = 0;
  logic [1:0]    cfg_mode = 0, cfg_taps = 0, cfg_gain = 0;
  logic [RW-1:0] cfg_ratio = 0;
  logic [AW-1:0] coef_addr = 0;
  logic [CW-1:0] coef_data = 0;
  logic [DW-1:0] in_data = 0;
  logic          out_valid, cfg_err;
  logic [DW-1:0] out_data;

  fir_decim_prog dut (
    .clk(clk), .rst(rst), .cfg_en(cfg_en), .cfg_mode(cfg_mode), .cfg_taps(cfg_taps),
    .cfg_gain(cfg_gain), .cfg_ratio(cfg_ratio), .coef_we(coef_we), .coef_addr(coef_addr),
    .coef_data(coef_data), .in_valid(in_valid), .in_data(in_data),
    .out_valid(out_valid), .out_data(out_data), .cfg_err(cfg_err)
  );

  always #2.5 clk = ~clk;

  int total = 0, bad = 0;
  bit done = 0;
  int hist [NT];
  int coef_m [NT];
  int ph;
  int b_en, b_mode, b_taps, b_gain, b_ratio;
  int exp_q [$];
  string tag_q [$];
  string cur_tag = "R2";

  task automatic check(input int act, input int expv, input string tag);
    total++;
    if (act != expv) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  function automatic int dec_b(input int m);
    return (m == 2) ? 2 : (m == 3) ? 4 : 1;
  endfunction

  function automatic bit illegal_b();
    return (b_taps == 3) || ((b_taps + 1) > b_ratio * dec_b(b_mode));
  endfunction

  function automatic bit bypass_b();
    return (b_en == 0) || (b_mode == 0) || illegal_b();
  endfunction

  function automatic int model_out();
    longint s = 0;
    longint sc;
    int n = (b_taps + 1) * 24;
    for (int k = 0; k < n; k++) s += longint'(coef_m[k]) * longint'(hist[k]);
    sc = s >>> (14 + b_gain);   // gain code 0..3 -> +1..-2 bit shift
    if (sc > 32767) return 32767;
    if (sc < -32768) return -32768;
    return int'(sc);
  endfunction

  always @(negedge clk) begin
    if (!rst && out_valid) begin
      if (exp_q.size() == 0) begin
        total++; bad++;
        $display("FAIL %s unexpected output actual=%0d expected=none", cur_tag, $signed(out_data));
      end else begin
        check(int'($signed(out_data)), exp_q.pop_front(), tag_q.pop_front());
      end
    end
  end

  task automatic drive_cfg(input int en, input int m, input int t, input int g, input int r);
    cfg_en = en[0]; cfg_mode = m[1:0]; cfg_taps = t[1:0]; cfg_gain = g[1:0]; cfg_ratio = r[RW-1:0];
    @(posedge clk); #1;
  endtask

  task automatic set_cfg(input int en, input int m, input int t, input int g, input int r);
    drive_cfg(0, 0, 0, 0, 1);
    drive_cfg(en, m, t, g, r);
    b_en = en; b_mode = m; b_taps = t; b_gain = g; b_ratio = r;
    for (int i = 0; i < NT; i++) hist[i] = 0;
    ph = 0;
    repeat (2) @(posedge clk);
    #1;
  endtask

  task automatic send(input int x);
    if (bypass_b()) begin
      exp_q.push_back(x); tag_q.push_back(cur_tag);
    end else begin
      for (int i = NT - 1; i > 0; i--) hist[i] = hist[i-1];
      hist[0] = x;
      ph++;
      if (ph == dec_b(b_mode)) begin
        ph = 0;
        exp_q.push_back(model_out()); tag_q.push_back(cur_tag);
      end
    end
    in_valid = 1; in_data = x[DW-1:0];
    @(posedge clk); #1;
    in_valid = 0;
    repeat (b_ratio - 1) @(posedge clk);
    if (b_ratio > 1) #1;
  endtask

  task automatic drain();
    repeat (14) @(posedge clk);
    #1;
    check(exp_q.size(), 0, {cur_tag, " R3 output count"});
    exp_q.delete(); tag_q.delete();
  endtask

  task automatic wcoef(input int a, input int v);
    coef_we = 1; coef_addr = a[AW-1:0]; coef_data = v[CW-1:0];
    @(posedge clk); #1;
    coef_we = 0;
    if (b_en == 0) coef_m[a] = v;
  endtask

  task automatic chk_err(input int expv, input string tag);
    @(negedge clk);
    check(int'(cfg_err), expv, tag);
    @(posedge clk); #1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    b_en = 0; b_mode = 0; b_taps = 0; b_gain = 0; b_ratio = 1; ph = 0;
    repeat (5) @(posedge clk);
    #1 rst = 0;
    @(negedge clk);
    check(int'(out_valid), 0, "R1 reset out_valid");
    check(int'(cfg_err), 0, "R1 reset cfg_err");
    @(posedge clk); #1;

    set_cfg(0, 0, 0, 1, 1);
    for (int k = 0; k < NT; k++) wcoef(k, (((k * 53 + 11) % 401) - 200) * 40);

    cur_tag = "R1 bypass mode";
    set_cfg(1, 0, 0, 1, 1);
    send(100); send(-5); send(32767); send(-32768); send(7);
    drain();
    cur_tag = "R1 disabled";
    set_cfg(0, 2, 1, 0, 1);
    send(1234); send(-4321); send(0); send(55);
    drain();

    for (int t = 0; t < 3; t++)
      for (int m = 1; m < 4; m++)
        for (int g = 0; g < 4; g++) begin
          cur_tag = $sformatf("R2 R3 R4 R5 taps=%0d mode=%0d gain=%0d", t, m, g);
          set_cfg(1, m, t, g, 3);
          send(16384);
          for (int i = 0; i < 75; i++) send(0);
          for (int i = 0; i < 30; i++) send(20000);
          for (int i = 0; i < 30; i++) send(-25000);
          drain();
        end

    cur_tag = "R7 too long for ratio";
    set_cfg(1, 1, 2, 1, 1);
    chk_err(1, "R7 err flag 72 taps ratio 1 dec 1");
    send(300); send(-301); send(302);
    drain();
    cur_tag = "R7 reserved length";
    set_cfg(1, 1, 3, 1, 3);
    chk_err(1, "R7 err flag reserved code");
    send(77); send(-78);
    drain();
    cur_tag = "R7 tight schedule";
    set_cfg(1, 3, 2, 1, 1);
    chk_err(0, "R7 legal 3 passes in 4 clocks");
    send(16384);
    for (int i = 0; i < 79; i++) send(0);
    for (int i = 0; i < 24; i++) send(-12000);
    drain();

    cur_tag = "R8 write while enabled";
    wcoef(0, 12345);
    set_cfg(1, 1, 0, 1, 3);
    send(16384); send(0); send(0); send(0);
    drain();
    cur_tag = "R8 write while disabled";
    set_cfg(0, 0, 0, 1, 1);
    wcoef(0, -7000);
    set_cfg(1, 1, 0, 1, 3);
    send(16384); send(0); send(0);
    drain();

    cur_tag = "R9 clear on change";
    set_cfg(1, 2, 0, 1, 3);
    send(20000); send(20000); send(20000);
    drain();
    set_cfg(1, 2, 0, 0, 3);
    send(16384);
    for (int i = 0; i < 29; i++) send(0);
    drain();

    cur_tag = "R6 saturation";
    set_cfg(0, 0, 0, 1, 1);
    for (int k = 0; k < 24; k++) wcoef(k, 16384);
    set_cfg(1, 1, 0, 0, 1);
    for (int i = 0; i < 30; i++) send(20000);
    for (int i = 0; i < 30; i++) send(-20000);
    drain();

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule